// File: doc/BRIEF.md
# Vertical Sync Source and Polarity Unit

This block decides which vertical sync pulse feeds the downstream sync processing. The candidates are the dedicated vertical sync input pin and a vertical sync recovered by an external composite sync separator. Both arrive as inputs that are synchronous to the pixel clock. The horizontal sync, `hs_in`, also arrives already normalized to active high. Software can force a source. Otherwise the block picks one itself: it keeps the pin while the pin keeps toggling, and falls back to the separator once the pin has been quiet for a set number of lines.

The selected pulse is brought to an active-high form. Its polarity is either forced by configuration or learned by measuring how many lines it spends high and how many it spends low. The shorter level is taken to be the active one. The result is then driven out with a programmable output polarity.

An optional alignment stage delays each edge of the normalized pulse to the next horizontal sync leading edge. This gives a fixed placement of the vertical edge relative to the line.

Three state machines carry the behaviour:

- **Source arbiter.**
  - States: `SRC_PIN` and `SRC_SEP`.
  - Transitions: *pin_edge* moves to `SRC_PIN` and restarts the line count. *line_timeout* moves to `SRC_PIN`→`SRC_SEP` when the count reaches `TIMEOUT_LINES`.
- **Polarity learner.**
  - States: `PD_SKIP` (the first, partial run is discarded), `PD_RUN1` (first full run being measured), `PD_RUN2` (second run) and `PD_LOCK` (decisions made).
  - Transition: each *level_change* advances one step.
  - From `PD_RUN2` onward, every *level_change* also re-decides the polarity.
- **Edge aligner.**
  - States: `AL_LOW`, `AL_ARM_RISE`, `AL_HIGH` and `AL_ARM_FALL`.
  - *arm* transitions: `AL_LOW`→`AL_ARM_RISE` and `AL_HIGH`→`AL_ARM_FALL`.
  - *disarm* transitions go back the other way when the input reverts before an hsync edge.
  - *commit* transitions move to the new level on an hsync leading edge.

Top module: `vsync_select_pol`

## Requirements
- R1: After reset, `vs_out` is 0 and the automatic source is the separator. Automatic polarity assumes active high. With defaults (automatic source, automatic polarity, `out_level`=1, `align_en`=0), a constant-high separator input with a quiet pin shows up as `vs_out`=1.
- R2: With `src_force`=1, `src_sel`=0 routes `vs_pin` and `src_sel`=1 routes `vs_sep`, whatever the automatic state.
- R3: With `src_force`=0, any change on `vs_pin` selects the pin from the next cycle. The separator is selected once `TIMEOUT_LINES` hsync leading edges have passed without a pin change.
- R4: With `pol_force`=0, polarity is learned from the selected source.
  - Level lengths are counted in hsync leading edges. The run cut short by the first change is discarded.
  - From the second complete run on, at each change the level with fewer edges is taken as active. A tie keeps the prior decision.
  - Until that point the source is treated as active high.
- R5: With `pol_force`=1, `pol_level`=1 treats the selected source as active high and `pol_level`=0 as active low.
- R6: `out_level`=1 drives `vs_out` high while active. `out_level`=0 drives it low while active.
- R7: With `align_en`=0, `vs_out` shows the normalized level of the inputs seen at the previous rising clock edge.
- R8: With `align_en`=1, the normalized level present in a cycle where `hs_in` rises from 0 to 1 is committed. It reaches `vs_out` two rising edges after that cycle, and the committed level is held between such cycles.
- R9: With `align_en`=1, a normalized pulse that begins and ends between two hsync leading edges never appears on `vs_out`.
- R10: A pin change in the same cycle as an hsync leading edge restarts the line count with that edge not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | Horizontal sync, active high, synchronous to clk |
| vs_pin | input | 1 | Vertical sync from the dedicated pin |
| vs_sep | input | 1 | Vertical sync from the composite sync separator |
| src_force | input | 1 | 1: source chosen by `src_sel`; 0: automatic choice |
| src_sel | input | 1 | Forced source: 0 pin, 1 separator |
| pol_force | input | 1 | 1: input polarity given by `pol_level`; 0: learned |
| pol_level | input | 1 | Forced input polarity: 1 active high, 0 active low |
| out_level | input | 1 | Output polarity: 1 active high, 0 active low |
| align_en | input | 1 | 1: edges held until the next hsync leading edge |
| vs_out | output | 1 | Selected, normalized vertical sync with programmed polarity |

## Verification
The assertions assume that `hs_in`, `vs_pin` and `vs_sep` are synchronous single-bit levels. They also assume that the configuration bits change only between clock edges, so an hsync leading edge is a single-cycle event seen once per line. The stimulus changes every input on the falling clock edge. It produces lines of fixed length with a two-cycle hsync pulse. Vertical pulses have short active runs and long inactive runs, so that the learned polarity settles on a defined answer. Directed segments place a pin change exactly on an hsync edge, and a brief pulse wholly inside a line, to reach the two cases that random timing rarely hits.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    typedef enum logic {
        SRC_PIN,
        SRC_SEP
    } src_state_t;

    typedef enum logic [1:0] {
        PD_SKIP,
        PD_RUN1,
        PD_RUN2,
        PD_LOCK
    } pol_state_t;

    typedef enum logic [1:0] {
        AL_LOW,
        AL_ARM_RISE,
        AL_HIGH,
        AL_ARM_FALL
    } al_state_t;

endpackage

// File: rtl/vsp_src_arb.sv
module vsp_src_arb
    import vsp_pkg::*;
#(
    parameter int TIMEOUT_LINES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_lead,
    input  logic vs_pin,
    input  logic src_force,
    input  logic src_sel,
    output logic use_sep
);
    localparam int CW = $clog2(TIMEOUT_LINES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(TIMEOUT_LINES);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_LINES - 1);

    src_state_t      st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            pin_d_q;
    logic            pin_edge;

    assign pin_edge = vs_pin ^ pin_d_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SRC_PIN: begin
                if (pin_edge) begin
                    cnt_d = '0;
                end else if (hs_lead) begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_d = CNT_FULL;
                        st_d  = SRC_SEP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SRC_SEP: begin
                if (pin_edge) begin
                    cnt_d = '0;
                    st_d  = SRC_PIN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= SRC_SEP;
            cnt_q   <= CNT_FULL;
            pin_d_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            pin_d_q <= vs_pin;
        end
    end

    always_comb begin
        use_sep = src_force ? src_sel : (st_q == SRC_SEP);
    end

    a_r3_edge_selects_pin: assert property (@(posedge clk) disable iff (!rst_n)
        pin_edge |=> (st_q == SRC_PIN));

    a_r3_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_PIN) |-> (cnt_q < CNT_FULL));

    a_r10_edge_beats_line: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_edge && hs_lead) |=> (cnt_q == '0));

endmodule

// File: rtl/vsp_pol_learn.sv
module vsp_pol_learn
    import vsp_pkg::*;
#(
    parameter int RUN_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_lead,
    input  logic vs_raw,
    output logic det_high
);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    pol_state_t       st_q, st_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [RUN_W-1:0] hi_q, hi_d;
    logic [RUN_W-1:0] lo_q, lo_d;
    logic [RUN_W-1:0] cmp_hi, cmp_lo;
    logic             raw_d_q;
    logic             det_q, det_d;
    logic             level_change;

    assign level_change = vs_raw ^ raw_d_q;
    assign cmp_hi = raw_d_q ? run_q : hi_q;
    assign cmp_lo = raw_d_q ? lo_q  : run_q;

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        hi_d  = hi_q;
        lo_d  = lo_q;
        det_d = det_q;
        if (level_change) begin
            run_d = '0;
            unique case (st_q)
                PD_SKIP: st_d = PD_RUN1;
                PD_RUN1: begin
                    if (raw_d_q) hi_d = run_q;
                    else         lo_d = run_q;
                    st_d = PD_RUN2;
                end
                PD_RUN2, PD_LOCK: begin
                    if (raw_d_q) hi_d = run_q;
                    else         lo_d = run_q;
                    if (cmp_hi < cmp_lo)      det_d = 1'b1;
                    else if (cmp_lo < cmp_hi) det_d = 1'b0;
                    st_d = PD_LOCK;
                end
            endcase
        end else if (hs_lead && run_q != RUN_MAX) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PD_SKIP;
            run_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            det_q   <= 1'b1;
            raw_d_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            run_q   <= run_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
            det_q   <= det_d;
            raw_d_q <= vs_raw;
        end
    end

    always_comb begin
        det_high = det_q;
    end

    a_r4_decide_on_change_only: assert property (@(posedge clk) disable iff (!rst_n)
        !level_change |=> $stable(det_q));

    a_r4_high_until_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != PD_LOCK) |-> det_q);

endmodule

// File: rtl/vsp_edge_align.sv
module vsp_edge_align
    import vsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_lead,
    input  logic vs_norm,
    output logic al_act
);
    al_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AL_LOW: begin
                if (vs_norm) st_d = hs_lead ? AL_HIGH : AL_ARM_RISE;
            end
            AL_ARM_RISE: begin
                if (!vs_norm)     st_d = AL_LOW;
                else if (hs_lead) st_d = AL_HIGH;
            end
            AL_HIGH: begin
                if (!vs_norm) st_d = hs_lead ? AL_LOW : AL_ARM_FALL;
            end
            AL_ARM_FALL: begin
                if (vs_norm)      st_d = AL_HIGH;
                else if (hs_lead) st_d = AL_LOW;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AL_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        al_act = (st_q == AL_HIGH) || (st_q == AL_ARM_FALL);
    end

    a_r8_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_lead |=> $stable(al_act));

    a_r8_commit_level: assert property (@(posedge clk) disable iff (!rst_n)
        hs_lead |=> (al_act == $past(vs_norm)));

    a_r9_disarm_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AL_ARM_RISE && !vs_norm) |=> (st_q == AL_LOW));

endmodule

// File: rtl/vsync_select_pol.sv
module vsync_select_pol #(
    parameter int TIMEOUT_LINES = 16,
    parameter int RUN_W         = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_in,
    input  logic vs_pin,
    input  logic vs_sep,
    input  logic src_force,
    input  logic src_sel,
    input  logic pol_force,
    input  logic pol_level,
    input  logic out_level,
    input  logic align_en,
    output logic vs_out
);
    logic hs_d_q;
    logic hs_lead;
    logic use_sep;
    logic vs_raw;
    logic det_high;
    logic act_high;
    logic vs_norm;
    logic al_act;
    logic vs_act;
    logic vs_out_q;

    assign hs_lead = hs_in & ~hs_d_q;

    vsp_src_arb #(
        .TIMEOUT_LINES (TIMEOUT_LINES)
    ) u_src_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_lead   (hs_lead),
        .vs_pin    (vs_pin),
        .src_force (src_force),
        .src_sel   (src_sel),
        .use_sep   (use_sep)
    );

    assign vs_raw = use_sep ? vs_sep : vs_pin;

    vsp_pol_learn #(
        .RUN_W (RUN_W)
    ) u_pol_learn (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_lead  (hs_lead),
        .vs_raw   (vs_raw),
        .det_high (det_high)
    );

    assign act_high = pol_force ? pol_level : det_high;
    assign vs_norm  = act_high ? vs_raw : ~vs_raw;

    vsp_edge_align u_edge_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_lead (hs_lead),
        .vs_norm (vs_norm),
        .al_act  (al_act)
    );

    assign vs_act = align_en ? al_act : vs_norm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_d_q   <= 1'b0;
            vs_out_q <= 1'b0;
        end else begin
            hs_d_q   <= hs_in;
            vs_out_q <= out_level ? vs_act : ~vs_act;
        end
    end

    assign vs_out = vs_out_q;

endmodule

// File: tb/vsync_select_pol_bench.sv
module vsync_select_pol_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_LINES    = 6;
    localparam int RUN_BITS   = 8;
    localparam int LINE       = 8;
    localparam int RMAX       = (1 << RUN_BITS) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b0;
    logic src_force = 1'b0, src_sel = 1'b0;
    logic pol_force = 1'b0, pol_level = 1'b1;
    logic out_level = 1'b1, align_en = 1'b0;
    logic vs_out;

    logic pin_gen = 1'b0, sep_gen = 1'b0;
    logic pin_man = 1'b0, sep_man = 1'b0;
    logic man_pin_en = 1'b1, man_sep_en = 1'b1;
    logic pin_run = 1'b1, sep_run = 1'b1;
    logic pin_act = 1'b1, sep_act = 1'b1;
    logic vs_pin_i, vs_sep_i;
    int   ln_pos = 0;
    int   pin_left = 5, sep_left = 7;

    int   n_chk = 0, n_fail = 0;
    logic chk_en = 1'b0;
    string cur_tag = "R1";

    assign vs_pin_i = man_pin_en ? pin_man : pin_gen;
    assign vs_sep_i = man_sep_en ? sep_man : sep_gen;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsync_select_pol #(
        .TIMEOUT_LINES (T_LINES),
        .RUN_W         (RUN_BITS)
    ) u_vsync_select_pol (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_in     (hs_in),
        .vs_pin    (vs_pin_i),
        .vs_sep    (vs_sep_i),
        .src_force (src_force),
        .src_sel   (src_sel),
        .pol_force (pol_force),
        .pol_level (pol_level),
        .out_level (out_level),
        .align_en  (align_en),
        .vs_out    (vs_out)
    );

    function automatic int run_len(input logic is_active);
        if (is_active) return int'($urandom_range(LINE * 3, LINE * 1));
        return int'($urandom_range(LINE * 12, LINE * 5));
    endfunction

    // stimulus generators: lines and two vertical sources
    always @(negedge clk) begin
        ln_pos = (ln_pos + 1) % LINE;
        hs_in <= (ln_pos < 2);
        if (pin_run) begin
            pin_left = pin_left - 1;
            if (pin_left <= 0) begin
                pin_gen <= ~pin_gen;
                pin_left = run_len((~pin_gen) == pin_act);
            end
        end
        if (sep_run) begin
            sep_left = sep_left - 1;
            if (sep_left <= 0) begin
                sep_gen <= ~sep_gen;
                sep_left = run_len((~sep_gen) == sep_act);
            end
        end
    end

    // reference model built from the requirements
    logic m_hs_d, m_pin_d, m_use_sep, m_raw_d, m_det, m_al, m_out;
    int   m_cnt, m_seen, m_run, m_hi, m_lo;

    always @(posedge clk) begin
        logic hl, pe, us, rw, eh, nm, ac, ch;
        if (!rst_n) begin
            m_hs_d = 0; m_pin_d = 0; m_use_sep = 1; m_cnt = T_LINES;
            m_raw_d = 0; m_det = 1; m_seen = 0; m_run = 0; m_hi = 0; m_lo = 0;
            m_al = 0; m_out = 0;
        end else begin
            hl = hs_in && !m_hs_d;
            pe = (vs_pin_i != m_pin_d);
            us = src_force ? src_sel : m_use_sep;
            rw = us ? vs_sep_i : vs_pin_i;
            eh = pol_force ? pol_level : m_det;
            nm = eh ? rw : !rw;
            ac = align_en ? m_al : nm;
            m_out = out_level ? ac : !ac;
            if (hl) m_al = nm;
            if (pe) begin
                m_cnt = 0; m_use_sep = 0;
            end else if (hl && m_cnt < T_LINES) begin
                m_cnt++;
                if (m_cnt == T_LINES) m_use_sep = 1;
            end
            ch = (rw != m_raw_d);
            if (ch) begin
                if (m_seen >= 1) begin
                    if (m_raw_d) m_hi = m_run; else m_lo = m_run;
                end
                if (m_seen >= 2) begin
                    if (m_hi < m_lo) m_det = 1;
                    else if (m_lo < m_hi) m_det = 0;
                end
                if (m_seen < 2) m_seen++;
                m_run = 0;
            end else if (hl && m_run < RMAX) begin
                m_run++;
            end
            m_raw_d = rw; m_hs_d = hs_in; m_pin_d = vs_pin_i;
        end
    end

    // continuous comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            n_chk++;
            if (vs_out !== m_out) begin
                n_fail++;
                $display("FAIL %s: vs_out=%0b expected %0b at %0t", cur_tag, vs_out, m_out, $time);
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: vs_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_phase(input string tag, input int cycles);
        cur_tag = tag;
        chk_en = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic wait_pos(input int pos);
        do @(posedge clk); while (ln_pos != pos);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd51877));
        // R1: reset state and defaults
        repeat (4) @(negedge clk);
        sep_man = 1'b1;
        @(negedge clk);
        check("R1 reset level", vs_out, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 default source sep, active high", vs_out, 1'b1);

        // R2: forced source
        man_pin_en = 0; man_sep_en = 0;
        pol_force = 1; pol_level = 1;
        src_force = 1; src_sel = 0;
        run_phase("R2 forced pin", 2500);
        src_sel = 1;
        run_phase("R2 forced sep", 2500);

        // R3: automatic source, pin stopping and restarting
        src_force = 0;
        run_phase("R3 auto pin alive", 2000);
        pin_run = 0;
        run_phase("R3 auto pin quiet", 2000);
        pin_run = 1;
        run_phase("R3 auto pin resumes", 2000);

        // R4: learned polarity, both senses
        pol_force = 0; src_force = 1; src_sel = 0; pin_act = 0;
        run_phase("R4 learned active low", 4000);
        pin_act = 1;
        run_phase("R4 learned active high", 4000);

        // R5: forced input polarity
        pol_force = 1; pol_level = 0;
        run_phase("R5 forced low", 2000);
        pol_level = 1;
        run_phase("R5 forced high", 2000);

        // R6: output polarity
        out_level = 0;
        run_phase("R6 output active low", 2000);
        out_level = 1;

        // R7 / R8: alignment off and on
        align_en = 0;
        run_phase("R7 passthrough", 2000);
        align_en = 1;
        run_phase("R8 aligned", 3000);

        // R8 directed: commit on an hsync edge, seen two edges later
        chk_en = 0;
        man_pin_en = 1; pin_man = 0;
        src_force = 1; src_sel = 0; pol_force = 1; pol_level = 1; out_level = 1;
        repeat (3 * LINE) @(negedge clk);
        wait_pos(2);
        @(negedge clk) pin_man = 1;
        wait_pos(0);
        @(negedge clk);
        check("R8 before commit", vs_out, 1'b0);
        @(negedge clk);
        check("R8 after commit", vs_out, 1'b1);

        // R9 directed: a pulse inside one line is dropped
        pin_man = 0;
        repeat (3 * LINE) @(negedge clk);
        wait_pos(2);
        @(negedge clk) pin_man = 1;
        @(negedge clk);
        @(negedge clk) pin_man = 0;
        for (int k = 0; k < 2 * LINE; k++) begin
            @(negedge clk);
            check("R9 short pulse dropped", vs_out, 1'b0);
        end

        // R10 directed: pin change on the hsync edge restarts the count
        align_en = 0; src_force = 0; man_sep_en = 1; sep_man = 0; pin_man = 0;
        repeat ((T_LINES + 2) * LINE) @(negedge clk);
        check("R10 setup on separator", vs_out, 1'b0);
        wait_pos(LINE - 1);
        @(negedge clk) pin_man = 1;
        repeat ((T_LINES - 1) * LINE + 5) @(negedge clk);
        check("R10 pin kept before timeout", vs_out, 1'b1);
        repeat (LINE) @(negedge clk);
        check("R10 separator after timeout", vs_out, 1'b0);

        // mixed random configurations
        man_pin_en = 0; man_sep_en = 0;
        for (int i = 0; i < 30; i++) begin
            src_force = $urandom_range(1, 0) != 0;
            src_sel   = $urandom_range(1, 0) != 0;
            pol_force = $urandom_range(1, 0) != 0;
            pol_level = $urandom_range(1, 0) != 0;
            out_level = $urandom_range(1, 0) != 0;
            align_en  = $urandom_range(1, 0) != 0;
            pin_run   = $urandom_range(3, 0) != 0;
            pin_act   = $urandom_range(1, 0) != 0;
            sep_act   = $urandom_range(1, 0) != 0;
            run_phase("R2 R3 R4 R5 R6 R7 R8 mixed", 1500);
        end

        chk_en = 0;
        summary();
        $finish;
    end

endmodule